// File: doc/BRIEF.md
# Serial Keyboard Protocol Responder

This block is the keyboard end of a serial channel. The host sends command bytes down the channel's transmit path, and the block answers two of them with fixed two-byte replies. The keyboard side reports key press and release events, each carrying a 7-bit key index and a release flag. The block turns each event into a scancode by looking up the index in an external translation table. The table is reached through a combinational index/code port pair, and its contents are set outside the block.

Replies and scancodes go into a byte queue. The host's receive path drains that queue one byte per read strobe. A receive-ready output tells the serial channel whether at least one byte is waiting.

A three-state machine orders the writes into the queue:

- **ST_IDLE** accepts commands and key events. A recognised command writes its first reply byte and moves to ST_TAIL (transition *cmd_hit*). Any other command is discarded. A key event with no recognised command is written at once and the state stays ST_IDLE.
- **ST_TAIL** writes the second reply byte. It moves to ST_KEY if a key event is being held (transition *tail_to_key*). Otherwise it returns to ST_IDLE (transition *tail_done*).
- **ST_KEY** writes the held key byte and returns to ST_IDLE (transition *key_done*).

Top module: `kbd_responder`

## Requirements
- R1: After reset the queue is empty, `rx_ready` is 0 and `rd_data` is 0x00.
- R2: Command byte 0x01 seen in ST_IDLE writes 0xFF into the queue on that clock edge, then 0x05 on the next edge.
- R3: Command byte 0x07 seen in ST_IDLE writes 0xFE, then 0x20 on the next edge.
- R4: A command byte other than 0x01 or 0x07 writes nothing into the queue.
- R5: A key event `key_event` drives `map_idx` = `key_event[6:0]`. The byte queued is {`key_event[7]`, `map_code[6:0]`}, so bit 7 is 1 for a release and 0 for a press.
- R6: The queue holds 256 bytes and returns them in arrival order. A write attempted while it holds 256 bytes is dropped. Fullness is judged by the occupancy at the start of the cycle.
- R7: When a two-byte reply meets a nearly full queue, each reply byte is kept or dropped on its own, according to the free space at the moment that byte is written.
- R8: A key event in the same cycle as a recognised command is queued after both reply bytes. A key event during ST_TAIL is also queued after the second reply byte.
- R9: Commands arriving outside ST_IDLE are ignored. Key events arriving in ST_KEY, or arriving in ST_TAIL while a key is already held, are ignored.
- R10: A read strobe `rd_en` loads the oldest byte into `rd_data` on the next edge and removes it from the queue. A read of an empty queue loads 0x00.
- R11: `rx_ready` goes to 1 on every accepted write. After a read with no accepted write in the same cycle, `rx_ready` stays 1 only if bytes remain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command byte strobe from the host transmit path |
| cmd_byte | input | 8 | Host command byte |
| key_valid | input | 1 | Key event strobe |
| key_event | input | 8 | Bit 7 is the release flag; bits 6:0 are the key index |
| map_idx | output | 7 | Index presented to the translation table |
| map_code | input | 7 | Translated code returned by the table in the same cycle |
| rd_en | input | 1 | Host read strobe; removes one byte from the queue |
| rd_data | output | 8 | Byte returned by the latest read |
| rx_ready | output | 1 | At least one byte is waiting in the queue |

## Verification
The bench presents a key event in the same cycle as a reset command, and in the cycle of the second reply byte. A design that wrote key bytes straight into the queue would put the scancode between 0xFF and 0x05, or ahead of them.

It fills the queue to 256 bytes and tries one more write, then refills it to 255 bytes and issues a reply command. An off-by-one fullness test would either lose the 256th byte or keep 0x05 while overwriting the oldest byte.

It also sends back-to-back commands, and a late key during ST_KEY. A design that did not ignore these would queue extra bytes.

Finally, it reads past the end of the queue. A wrong empty guard would return stale data instead of 0x00, or would leave `rx_ready` high.

// File: rtl/kbd_pkg.sv
`timescale 1ns/1ps
package kbd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAIL = 2'd1,
        ST_KEY  = 2'd2
    } kbd_state_e;

    localparam logic [7:0] CMD_RESET       = 8'h01;
    localparam logic [7:0] CMD_LAYOUT      = 8'h07;
    localparam logic [7:0] RSP_RESET_LEAD  = 8'hFF;
    localparam logic [7:0] RSP_RESET_TAIL  = 8'h05;
    localparam logic [7:0] RSP_LAYOUT_LEAD = 8'hFE;
    localparam logic [7:0] RSP_LAYOUT_TAIL = 8'h20;

endpackage

// File: rtl/kbd_key_format.sv
`timescale 1ns/1ps
module kbd_key_format (
    input  logic [7:0] key_event,
    output logic [6:0] map_idx,
    input  logic [6:0] map_code,
    output logic [7:0] key_byte
);
    // Table index comes from the low bits; the release flag passes straight through.
    always_comb begin
        map_idx  = key_event[6:0];
        key_byte = {key_event[7], map_code};
    end
endmodule

// File: rtl/kbd_cmd_fsm.sv
`timescale 1ns/1ps
module kbd_cmd_fsm
    import kbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       key_valid,
    input  logic [7:0] key_byte,
    output logic       enq_valid,
    output logic [7:0] enq_byte,
    output kbd_state_e state_o
);
    kbd_state_e state_q, state_d;
    logic [7:0] tail_q;
    logic [7:0] hold_q;
    logic       hold_v;
    logic       cmd_hit;
    logic       is_reset_cmd;

    assign is_reset_cmd = (cmd_byte == CMD_RESET);
    assign cmd_hit      = cmd_valid && (is_reset_cmd || cmd_byte == CMD_LAYOUT);
    assign state_o      = state_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_hit) state_d = ST_TAIL;
            ST_TAIL: state_d = (hold_v || key_valid) ? ST_KEY : ST_IDLE;
            ST_KEY:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Pending reply tail and deferred key byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail_q <= '0;
            hold_q <= '0;
            hold_v <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_hit) begin
                        tail_q <= is_reset_cmd ? RSP_RESET_TAIL : RSP_LAYOUT_TAIL;
                        if (key_valid) begin
                            hold_q <= key_byte;
                            hold_v <= 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (key_valid && !hold_v) begin
                        hold_q <= key_byte;
                        hold_v <= 1'b1;
                    end
                end
                ST_KEY:  hold_v <= 1'b0;
                default: hold_v <= 1'b0;
            endcase
        end
    end

    // Output logic: one queue write per cycle at most
    always_comb begin
        enq_valid = 1'b0;
        enq_byte  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_hit) begin
                    enq_valid = 1'b1;
                    enq_byte  = is_reset_cmd ? RSP_RESET_LEAD : RSP_LAYOUT_LEAD;
                end else if (key_valid) begin
                    enq_valid = 1'b1;
                    enq_byte  = key_byte;
                end
            end
            ST_TAIL: begin
                enq_valid = 1'b1;
                enq_byte  = tail_q;
            end
            ST_KEY: begin
                enq_valid = 1'b1;
                enq_byte  = hold_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/kbd_byte_queue.sv
`timescale 1ns/1ps
module kbd_byte_queue #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    push_byte,
    input  logic          pop,
    output logic [7:0]    pop_byte,
    output logic          not_empty,
    output logic [AW:0]   level
);
    localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   lvl_q, lvl_d;
    logic          push_ok, pop_ok, rdy_d;

    assign push_ok = push && (lvl_q != FULL_LVL);
    assign pop_ok  = pop  && (lvl_q != '0);
    assign level   = lvl_q;

    always_comb begin
        lvl_d = lvl_q + {{AW{1'b0}}, push_ok} - {{AW{1'b0}}, pop_ok};
        if (push_ok)  rdy_d = 1'b1;
        else if (pop) rdy_d = (lvl_d != '0);
        else          rdy_d = not_empty;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= push_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp        <= '0;
            rp        <= '0;
            lvl_q     <= '0;
            pop_byte  <= '0;
            not_empty <= 1'b0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
            if (pop)     pop_byte <= pop_ok ? mem[rp] : 8'h00;
            lvl_q     <= lvl_d;
            not_empty <= rdy_d;
        end
    end
endmodule

// File: rtl/kbd_responder.sv
`timescale 1ns/1ps
module kbd_responder
    import kbd_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       key_valid,
    input  logic [7:0] key_event,
    output logic [6:0] map_idx,
    input  logic [6:0] map_code,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rx_ready
);
    logic [7:0]  key_byte;
    logic        enq_valid;
    logic [7:0]  enq_byte;
    kbd_state_e  fsm_state;
    logic [AW:0] q_level;

    kbd_key_format u_fmt (
        .key_event (key_event),
        .map_idx   (map_idx),
        .map_code  (map_code),
        .key_byte  (key_byte)
    );

    kbd_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .key_valid (key_valid),
        .key_byte  (key_byte),
        .enq_valid (enq_valid),
        .enq_byte  (enq_byte),
        .state_o   (fsm_state)
    );

    kbd_byte_queue #(.DEPTH(DEPTH)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (enq_valid),
        .push_byte (enq_byte),
        .pop       (rd_en),
        .pop_byte  (rd_data),
        .not_empty (rx_ready),
        .level     (q_level)
    );
endmodule

// File: rtl/kbd_responder_chk.sv
`timescale 1ns/1ps
module kbd_responder_chk
    import kbd_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [7:0]  cmd_byte,
    input logic        rd_en,
    input logic [7:0]  rd_data,
    input logic        rx_ready,
    input logic        enq_valid,
    input logic [7:0]  enq_byte,
    input kbd_state_e  fsm_state,
    input logic [AW:0] q_level
);
    localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        q_level <= FULL_LVL);                                                    // R6

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !rd_en && q_level == FULL_LVL) |=> (q_level == FULL_LVL)); // R6

    AST_RESET_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && cmd_valid && cmd_byte == CMD_RESET)
        |=> (enq_valid && enq_byte == RSP_RESET_TAIL));                          // R2

    AST_LAYOUT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && cmd_valid && cmd_byte == CMD_LAYOUT)
        |=> (enq_valid && enq_byte == RSP_LAYOUT_TAIL));                         // R3

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && q_level == '0) |=> (rd_data == 8'h00));                        // R10

    AST_ENQ_RAISES_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && q_level != FULL_LVL) |=> rx_ready);                        // R11

    AST_LAST_READ_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !enq_valid && q_level <= 1) |=> !rx_ready);                    // R11
endmodule

bind kbd_responder kbd_responder_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rx_ready  (rx_ready),
    .enq_valid (enq_valid),
    .enq_byte  (enq_byte),
    .fsm_state (fsm_state),
    .q_level   (q_level)
);

// File: tb/sim_kbd_responder.sv
`timescale 1ns/1ps
module sim_kbd_responder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic       key_valid = 1'b0;
    logic [7:0] key_event = '0;
    logic [6:0] map_idx;
    logic [6:0] map_code;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rx_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [7:0] model [$];

    always #2.5 clk = ~clk;

    function automatic logic [6:0] tbl(input logic [6:0] i);
        return 7'((int'(i) * 37 + 11) % 128);
    endfunction

    assign map_code = tbl(map_idx);

    kbd_responder u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .key_valid(key_valid), .key_event(key_event), .map_idx(map_idx),
        .map_code(map_code), .rd_en(rd_en), .rd_data(rd_data), .rx_ready(rx_ready)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic void mpush(input logic [7:0] b);
        if (model.size() < 256) model.push_back(b);
    endfunction

    function automatic logic [7:0] keyb(input logic [7:0] ev);
        return {ev[7], tbl(ev[6:0])};
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One read; compare to model (R10, R6) and ready flag (R11)
    task automatic read_one(input string req);
        logic [7:0] exp;
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        exp = (model.size() != 0) ? model.pop_front() : 8'h00;
        check(req, rd_data, exp);
        check("R11 ready after read", {7'd0, rx_ready}, {7'd0, model.size() != 0});
    endtask

    task automatic drain(input string req);
        while (model.size() != 0) read_one(req);
    endtask

    task automatic send_cmd(input logic [7:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_key(input logic [7:0] ev);
        @(negedge clk);
        key_valid = 1'b1; key_event = ev;
        #1;
        check("R5 map_idx", {1'b0, map_idx}, {1'b0, ev[6:0]});
        @(negedge clk);
        key_valid = 1'b0;
        mpush(keyb(ev));
    endtask

    task automatic t_reset_state();
        check("R1 rx_ready", {7'd0, rx_ready}, 8'h00);
        check("R1 rd_data", rd_data, 8'h00);
        read_one("R1 R10 empty read");
    endtask

    task automatic t_reset_cmd();
        send_cmd(8'h01); mpush(8'hFF); mpush(8'h05);
        idle(2);
        check("R11 ready after reply", {7'd0, rx_ready}, 8'h01);
        drain("R2 reset reply");
        read_one("R10 read past end");
    endtask

    task automatic t_layout_cmd();
        send_cmd(8'h07); mpush(8'hFE); mpush(8'h20);
        idle(2);
        drain("R3 layout reply");
    endtask

    task automatic t_other_cmds();
        send_cmd(8'h00); send_cmd(8'h02); send_cmd(8'hFF); send_cmd(8'h81);
        idle(3);
        check("R4 no reply ready", {7'd0, rx_ready}, 8'h00);
        read_one("R4 nothing queued");
    endtask

    task automatic t_keys();
        send_key(8'h05); send_key(8'h85); send_key(8'h7F); send_key(8'h00);
        idle(1);
        read_one("R5 press");
        check("R11 ready while bytes remain", {7'd0, rx_ready}, 8'h01);
        drain("R5 key bytes");
    endtask

    task automatic t_key_with_cmd();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = 8'h01; key_valid = 1'b1; key_event = 8'h9A;
        @(negedge clk);
        cmd_valid = 1'b0; key_valid = 1'b0;
        mpush(8'hFF); mpush(8'h05); mpush(keyb(8'h9A));
        idle(3);
        drain("R8 key after same-cycle reply");
    endtask

    task automatic t_key_in_tail();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = 8'h07;
        @(negedge clk);
        cmd_valid = 1'b0; key_valid = 1'b1; key_event = 8'h33;
        @(negedge clk);
        key_valid = 1'b0;
        mpush(8'hFE); mpush(8'h20); mpush(keyb(8'h33));
        idle(3);
        drain("R8 key during tail");
    endtask

    task automatic t_busy_ignored();
        // second command lands in ST_TAIL
        @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = 8'h01;
        @(negedge clk);
        cmd_byte = 8'h07;
        @(negedge clk);
        cmd_valid = 1'b0;
        mpush(8'hFF); mpush(8'h05);
        idle(3);
        drain("R9 cmd during tail");
        read_one("R9 no extra bytes");
        // late key lands in ST_KEY
        @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = 8'h01; key_valid = 1'b1; key_event = 8'h11;
        @(negedge clk);
        cmd_valid = 1'b0; key_valid = 1'b0;
        @(negedge clk);
        key_valid = 1'b1; key_event = 8'h22;
        @(negedge clk);
        key_valid = 1'b0;
        mpush(8'hFF); mpush(8'h05); mpush(keyb(8'h11));
        idle(3);
        drain("R9 key during key state");
        read_one("R9 no late key");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 256; i++) send_key(8'(i));
        send_key(8'h44);                  // dropped: queue full
        idle(2);
        check("R6 full ready", {7'd0, rx_ready}, 8'h01);
        drain("R6 full order");
        read_one("R6 extra dropped");
        for (int i = 0; i < 255; i++) send_key(8'(i + 3));
        send_cmd(8'h01); mpush(8'hFF); mpush(8'h05);
        idle(3);
        drain("R7 partial reply");
        read_one("R7 tail dropped");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        t_reset_state();
        t_reset_cmd();
        t_layout_cmd();
        t_other_cmds();
        t_keys();
        t_key_with_cmd();
        t_key_in_tail();
        t_busy_ignored();
        t_overflow();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule